// File: doc/BRIEF.md
# Multi-bank flash operation arbiter

This block sits between the request port of a 128-Mbit flash array model (8M words of 16 bits) and its internal program/erase controller. Each incoming request carries a kind and a 23-bit word address. The block turns the address into a bank index and an erase-block index. The map is uneven: the topmost 64 Kwords are split into four small blocks, and everything below is split into uniform 64-Kword blocks. The block then grants or refuses the request according to what is already active in the array.

It follows a single long-running program or erase operation through its life: start, suspend, resume and completion. While an erase is suspended it can also follow one program nested inside it. Reads are let through to any bank that is not busy. A suspended operation protects only the word or block it owns. A burst read can step word by word past bank boundaries. The controller drives suspend, resume and completion strobes. These strobes take effect before the request that arrives in the same cycle is judged.

Top module: `flash_bank_arbiter`

## Requirements
- R1: The reported bank index is address bits [22:19], giving 16 banks of 512 Kwords.
- R2: The reported block index is addr[22:16] when addr[22:16] is not 127. Otherwise it is 127 plus addr[15:14]. This gives 131 blocks, numbered 0 to 130.
- R3: Request kinds are encoded 0 = read, 1 = program, 2 = erase, 3 = burst step. The response comes one clock after a cycle with `req_valid` high: exactly one of `grant` or `reject` pulses, and `rsp_bank`/`rsp_block` show the decoded target. With no request, neither pulses.
- R4: A program or erase is granted when no operation is held. While an operation is active and not suspended, any further program or erase is rejected, and `busy` reads 1.
- R5: While an operation runs unsuspended, a read to its bank is rejected and a read to any other bank is granted.
- R6: A suspend strobe on a running, non-nested operation sets `suspended` and clears `busy`. A resume strobe reverses this. Either strobe has no effect when it does not apply.
- R7: While an erase is suspended, reads to any other block are granted, and so is one program to any other block. A read or program to the erasing block is rejected. An erase request is rejected.
- R8: While a program is suspended, reads to any word except the programmed one are granted. A read of that word is rejected, and so is any program or erase.
- R9: A program nested in a suspended erase makes `busy` read 1 and rejects reads to its bank. A resume strobe is ignored while the nested program is active. A completion strobe first ends the nested program, which leaves the erase suspended.
- R10: A completion strobe ends a running, unsuspended operation and clears `busy`. A completion strobe with nothing running changes nothing.
- R11: A burst step targets the last granted read address plus one, wrapping at the top of the address space. The step is judged under the read rules and may cross bank boundaries. A step is rejected if no read has been granted since reset; in that case the address before the first read is taken as 0. A rejected step does not advance.
- R12: Completion, suspend and resume strobes act before a request in the same cycle is judged. A suspend is not applied if a completion arrives with it. A resume is judged against the nested state held at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Request kind (0 read, 1 program, 2 erase, 3 burst step) |
| req_addr | input | 23 | Word address (ignored for burst step) |
| ctl_done | input | 1 | Controller strobe: current operation finished |
| ctl_suspend | input | 1 | Controller strobe: suspend current operation |
| ctl_resume | input | 1 | Controller strobe: resume suspended operation |
| grant | output | 1 | Request of previous cycle admitted |
| reject | output | 1 | Request of previous cycle refused |
| rsp_bank | output | 4 | Bank index of the last request |
| rsp_block | output | 8 | Erase-block index of the last request |
| busy | output | 1 | A program or erase is running unsuspended |
| suspended | output | 1 | The held operation is suspended |

## Verification
The collision that matters is a controller strobe and a request admission landing in the same cycle. For example, a completion meets a new program, a suspend meets a read of the word being programmed, or a resume meets a nested program. Directed steps place these pairs on one edge on purpose. A random phase then fires completion, suspend and resume strobes in about one cycle in ten alongside requests, with addresses aimed at the held word, the held bank and the top bank. The bench model applies the strobes first and then the admission rules. It compares `grant`, `reject`, `busy`, `suspended` and the decoded indices after every step.

// File: rtl/fba_pkg.sv
// Package: shared request-kind encoding for the flash operation arbiter.
// Assumes the two-bit request kind on the top-level port uses this order.
package fba_pkg;
    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_PROG  = 2'd1,
        K_ERASE = 2'd2,
        K_BURST = 2'd3
    } fba_kind_e;
endpackage

// File: rtl/fba_addr_map.sv
// Address decoder: word address -> bank index and erase-block index.
// Assumes the bank bits and main-block bits are the top address bits, and
// that the last main-block slot is subdivided into parameter blocks.
module fba_addr_map #(
    parameter int ADDR_W   = 23,
    parameter int BANK_W   = 4,
    parameter int MAIN_SH  = 16,
    parameter int PARAM_SH = 14,
    parameter int BLK_W    = 8
) (
    input  logic [ADDR_W-PARAM_SH-1:0] addr_hi,
    output logic [BANK_W-1:0]          bank,
    output logic [BLK_W-1:0]           blk
);
    localparam int HI_W     = ADDR_W - PARAM_SH;
    localparam int MAIN_W   = ADDR_W - MAIN_SH;
    localparam int PARAM_W  = MAIN_SH - PARAM_SH;
    localparam int TOP_MAIN = (1 << MAIN_W) - 1;

    logic [MAIN_W-1:0]  main_idx;
    logic [PARAM_W-1:0] param_idx;

    assign bank      = addr_hi[HI_W-1 -: BANK_W];
    assign main_idx  = addr_hi[HI_W-1 -: MAIN_W];
    assign param_idx = addr_hi[PARAM_W-1:0];

    // Purpose: pick uniform block index, or split the top slot into small blocks.
    always_comb begin
        if (main_idx == MAIN_W'(TOP_MAIN))
            blk = BLK_W'(TOP_MAIN) + BLK_W'(param_idx);
        else
            blk = BLK_W'(main_idx);
    end
endmodule

// File: rtl/fba_op_tracker.sv
// Operation tracker: holds the single primary program/erase and an optional
// program nested inside a suspended erase. Applies controller strobes to the
// held state combinationally (the "effective" state used for admission), then
// registers the effective state plus any operation launched this cycle.
// Assumes at most one launch per cycle, chosen by the admission logic.
module fba_op_tracker #(
    parameter int ADDR_W = 23,
    parameter int BANK_W = 4,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              susp_i,
    input  logic              resume_i,
    input  logic              start_prim_i,
    input  logic              start_erase_i,
    input  logic              start_nest_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic [BANK_W-1:0] tgt_bank_i,
    input  logic [BLK_W-1:0]  tgt_blk_i,
    output logic              e_pact,
    output logic              e_perase,
    output logic              e_psusp,
    output logic [BANK_W-1:0] e_pbank,
    output logic [BLK_W-1:0]  e_pblk,
    output logic [ADDR_W-1:0] e_paddr,
    output logic              e_nact,
    output logic [BANK_W-1:0] e_nbank,
    output logic              q_pact,
    output logic              q_perase,
    output logic              q_psusp,
    output logic              q_nact
);
    logic [BANK_W-1:0] q_pbank;
    logic [BLK_W-1:0]  q_pblk;
    logic [ADDR_W-1:0] q_paddr;
    logic [BANK_W-1:0] q_nbank;

    // Purpose: apply completion, then suspend, then resume to the held state.
    always_comb begin
        e_pact   = q_pact;
        e_perase = q_perase;
        e_psusp  = q_psusp;
        e_pbank  = q_pbank;
        e_pblk   = q_pblk;
        e_paddr  = q_paddr;
        e_nact   = q_nact;
        e_nbank  = q_nbank;
        if (done_i && q_nact) begin
            e_nact = 1'b0;
        end else if (done_i && q_pact && !q_psusp) begin
            e_pact  = 1'b0;
            e_psusp = 1'b0;
        end
        if (susp_i && q_pact && !q_psusp && !q_nact && !done_i)
            e_psusp = 1'b1;
        if (resume_i && q_pact && q_psusp && !q_nact)
            e_psusp = 1'b0;
    end

    // Purpose: register effective state and record a newly launched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_pact   <= 1'b0;
            q_perase <= 1'b0;
            q_psusp  <= 1'b0;
            q_pbank  <= '0;
            q_pblk   <= '0;
            q_paddr  <= '0;
            q_nact   <= 1'b0;
            q_nbank  <= '0;
        end else begin
            q_pact   <= e_pact;
            q_perase <= e_perase;
            q_psusp  <= e_psusp;
            q_pbank  <= e_pbank;
            q_pblk   <= e_pblk;
            q_paddr  <= e_paddr;
            q_nact   <= e_nact;
            q_nbank  <= e_nbank;
            if (start_prim_i) begin
                q_pact   <= 1'b1;
                q_perase <= start_erase_i;
                q_psusp  <= 1'b0;
                q_pbank  <= tgt_bank_i;
                q_pblk   <= tgt_blk_i;
                q_paddr  <= tgt_addr_i;
            end
            if (start_nest_i) begin
                q_nact  <= 1'b1;
                q_nbank <= tgt_bank_i;
            end
        end
    end
endmodule

// File: rtl/fba_admit.sv
// Admission logic: judges one request against the effective operation state.
// Assumes the effective state already reflects this cycle's controller strobes.
module fba_admit
    import fba_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int BANK_W = 4,
    parameter int BLK_W  = 8
) (
    input  logic              req_valid,
    input  fba_kind_e         kind,
    input  logic              burst_open,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [BANK_W-1:0] tgt_bank,
    input  logic [BLK_W-1:0]  tgt_blk,
    input  logic              e_pact,
    input  logic              e_perase,
    input  logic              e_psusp,
    input  logic [BANK_W-1:0] e_pbank,
    input  logic [BLK_W-1:0]  e_pblk,
    input  logic [ADDR_W-1:0] e_paddr,
    input  logic              e_nact,
    input  logic [BANK_W-1:0] e_nbank,
    output logic              accept,
    output logic              start_prim,
    output logic              start_erase,
    output logic              start_nest
);
    logic rd_ok;

    // Purpose: a read is refused by a busy bank or by the word/block a suspended op owns.
    always_comb begin
        rd_ok = 1'b1;
        if (e_nact && tgt_bank == e_nbank)                      rd_ok = 1'b0;
        if (e_pact && !e_psusp && tgt_bank == e_pbank)          rd_ok = 1'b0;
        if (e_pact && e_psusp && !e_perase && tgt_addr == e_paddr) rd_ok = 1'b0;
        if (e_pact && e_psusp && e_perase && tgt_blk == e_pblk)  rd_ok = 1'b0;
    end

    // Purpose: decide grant and which operation, if any, is launched.
    always_comb begin
        accept      = 1'b0;
        start_prim  = 1'b0;
        start_erase = 1'b0;
        start_nest  = 1'b0;
        if (req_valid) begin
            case (kind)
                K_READ:  accept = rd_ok;
                K_BURST: accept = rd_ok && burst_open;
                K_PROG: begin
                    if (!e_pact) begin
                        accept     = 1'b1;
                        start_prim = 1'b1;
                    end else if (e_perase && e_psusp && !e_nact && tgt_blk != e_pblk) begin
                        accept     = 1'b1;
                        start_nest = 1'b1;
                    end
                end
                K_ERASE: begin
                    if (!e_pact) begin
                        accept      = 1'b1;
                        start_prim  = 1'b1;
                        start_erase = 1'b1;
                    end
                end
                default: accept = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/flash_bank_arbiter.sv
// Top: multi-bank flash operation arbiter. Decodes the request target,
// tracks the burst-read pointer, judges the request and registers the
// response one clock later. Assumes controller strobes are single-cycle.
module flash_bank_arbiter
    import fba_pkg::*;
#(
    parameter int ADDR_W   = 23,
    parameter int BANK_W   = 4,
    parameter int MAIN_SH  = 16,
    parameter int PARAM_SH = 14,
    localparam int BLK_W   = $clog2((1 << (ADDR_W - MAIN_SH)) - 1 + (1 << (MAIN_SH - PARAM_SH)))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ctl_done,
    input  logic              ctl_suspend,
    input  logic              ctl_resume,
    output logic              grant,
    output logic              reject,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [BLK_W-1:0]  rsp_block,
    output logic              busy,
    output logic              suspended
);
    fba_kind_e         kind;
    logic [ADDR_W-1:0] burst_ptr;
    logic              burst_open;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BANK_W-1:0] tgt_bank;
    logic [BLK_W-1:0]  tgt_blk;

    logic              e_pact, e_perase, e_psusp, e_nact;
    logic [BANK_W-1:0] e_pbank, e_nbank;
    logic [BLK_W-1:0]  e_pblk;
    logic [ADDR_W-1:0] e_paddr;
    logic              prim_act, prim_erase, prim_susp, nest_act;
    logic              accept, start_prim, start_erase, start_nest;

    assign kind     = fba_kind_e'(req_kind);
    assign tgt_addr = (kind == K_BURST) ? burst_ptr + ADDR_W'(1) : req_addr;

    fba_addr_map #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAIN_SH(MAIN_SH),
        .PARAM_SH(PARAM_SH), .BLK_W(BLK_W)
    ) u_map (
        .addr_hi(tgt_addr[ADDR_W-1:PARAM_SH]),
        .bank   (tgt_bank),
        .blk    (tgt_blk)
    );

    fba_op_tracker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_i       (ctl_done),
        .susp_i       (ctl_suspend),
        .resume_i     (ctl_resume),
        .start_prim_i (start_prim),
        .start_erase_i(start_erase),
        .start_nest_i (start_nest),
        .tgt_addr_i   (tgt_addr),
        .tgt_bank_i   (tgt_bank),
        .tgt_blk_i    (tgt_blk),
        .e_pact       (e_pact),
        .e_perase     (e_perase),
        .e_psusp      (e_psusp),
        .e_pbank      (e_pbank),
        .e_pblk       (e_pblk),
        .e_paddr      (e_paddr),
        .e_nact       (e_nact),
        .e_nbank      (e_nbank),
        .q_pact       (prim_act),
        .q_perase     (prim_erase),
        .q_psusp      (prim_susp),
        .q_nact       (nest_act)
    );

    fba_admit #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_admit (
        .req_valid  (req_valid),
        .kind       (kind),
        .burst_open (burst_open),
        .tgt_addr   (tgt_addr),
        .tgt_bank   (tgt_bank),
        .tgt_blk    (tgt_blk),
        .e_pact     (e_pact),
        .e_perase   (e_perase),
        .e_psusp    (e_psusp),
        .e_pbank    (e_pbank),
        .e_pblk     (e_pblk),
        .e_paddr    (e_paddr),
        .e_nact     (e_nact),
        .e_nbank    (e_nbank),
        .accept     (accept),
        .start_prim (start_prim),
        .start_erase(start_erase),
        .start_nest (start_nest)
    );

    // Purpose: register the response and advance the burst pointer on granted reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant      <= 1'b0;
            reject     <= 1'b0;
            rsp_bank   <= '0;
            rsp_block  <= '0;
            burst_ptr  <= '0;
            burst_open <= 1'b0;
        end else begin
            grant  <= accept;
            reject <= req_valid && !accept;
            if (req_valid) begin
                rsp_bank  <= tgt_bank;
                rsp_block <= tgt_blk;
            end
            if (accept && (kind == K_READ || kind == K_BURST)) begin
                burst_ptr  <= tgt_addr;
                burst_open <= 1'b1;
            end
        end
    end

    assign busy      = (prim_act && !prim_susp) || nest_act;
    assign suspended = prim_act && prim_susp;
endmodule

// File: rtl/fba_checker.sv
// Checker: temporal properties of the arbiter, bound to the top module.
// Assumes the bound instance exposes its tracker state signals by name.
module fba_checker #(
    parameter int BANK_W   = 4,
    parameter int BLK_W    = 8,
    parameter int BLK_SH   = 3,
    parameter int TOP_BLK  = 127,
    parameter int LAST_BLK = 130
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ctl_suspend,
    input logic              ctl_resume,
    input logic              grant,
    input logic              reject,
    input logic [BANK_W-1:0] rsp_bank,
    input logic [BLK_W-1:0]  rsp_block,
    input logic              suspended,
    input logic              prim_act,
    input logic              prim_susp,
    input logic              prim_erase,
    input logic              nest_act
);
    p_one_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant ^ reject));

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || reject));

    p_block_in_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || reject) |->
            ((rsp_block < BLK_W'(TOP_BLK)) ? ((rsp_block >> BLK_SH) == BLK_W'(rsp_bank))
                                           : (rsp_bank == '1 && rsp_block <= BLK_W'(LAST_BLK))));

    p_susp_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(ctl_suspend));

    p_nest_in_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nest_act |-> (prim_act && prim_susp && prim_erase));

    p_resume_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_act && ctl_resume) |=> suspended);
endmodule

bind flash_bank_arbiter fba_checker #(
    .BANK_W  (BANK_W),
    .BLK_W   (BLK_W),
    .BLK_SH  (ADDR_W - MAIN_SH - BANK_W),
    .TOP_BLK ((1 << (ADDR_W - MAIN_SH)) - 1),
    .LAST_BLK((1 << (ADDR_W - MAIN_SH)) - 2 + (1 << (MAIN_SH - PARAM_SH)))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ctl_suspend(ctl_suspend),
    .ctl_resume (ctl_resume),
    .grant      (grant),
    .reject     (reject),
    .rsp_bank   (rsp_bank),
    .rsp_block  (rsp_block),
    .suspended  (suspended),
    .prim_act   (prim_act),
    .prim_susp  (prim_susp),
    .prim_erase (prim_erase),
    .nest_act   (nest_act)
);

// File: tb/flash_bank_arbiter_test.sv
module flash_bank_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [22:0] req_addr = '0;
    logic        ctl_done = 1'b0, ctl_suspend = 1'b0, ctl_resume = 1'b0;
    logic        grant, reject, busy, suspended;
    logic [3:0]  rsp_bank;
    logic [7:0]  rsp_block;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // bench model state, built from the requirements
    bit          m_pa, m_pe, m_ps, m_na, m_bv;
    logic [3:0]  m_pb, m_nb;
    logic [7:0]  m_pk;
    logic [22:0] m_pw, m_bp;

    always #4 clk = ~clk;

    flash_bank_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .ctl_done(ctl_done), .ctl_suspend(ctl_suspend),
        .ctl_resume(ctl_resume), .grant(grant), .reject(reject),
        .rsp_bank(rsp_bank), .rsp_block(rsp_block), .busy(busy), .suspended(suspended)
    );

    // R1: bank = addr[22:19]
    function automatic logic [3:0] f_bank(logic [22:0] a);
        return a[22:19];
    endfunction

    // R2: uniform blocks below the top 64 Kwords, 127 + addr[15:14] inside it
    function automatic logic [7:0] f_blk(logic [22:0] a);
        if (a[22:16] == 7'h7F) return 8'd127 + {6'd0, a[15:14]};
        return {1'b0, a[22:16]};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One bench step: drive at negedge, predict, check at the following negedge.
    task automatic step(input bit v, input logic [1:0] k, input logic [22:0] a,
                        input bit d, input bit s, input bit r, input string tag);
        bit ea, ee, es, en, rd_ok, ok, xb, xs;
        logic [3:0] eb, enb, tb;
        logic [7:0] ek, tk;
        logic [22:0] ew, ta;
        req_valid = v; req_kind = k; req_addr = a;
        ctl_done = d; ctl_suspend = s; ctl_resume = r;
        ea = m_pa; ee = m_pe; es = m_ps; en = m_na;
        eb = m_pb; enb = m_nb; ek = m_pk; ew = m_pw;
        // R12: strobes first, then the request
        if (d && m_na) en = 0;
        else if (d && m_pa && !m_ps) begin ea = 0; es = 0; end
        if (s && m_pa && !m_ps && !m_na && !d) es = 1;
        if (r && m_pa && m_ps && !m_na) es = 0;
        ta = (k == 2'd3) ? m_bp + 23'd1 : a;
        tb = f_bank(ta);
        tk = f_blk(ta);
        rd_ok = !(en && tb == enb) && !(ea && !es && tb == eb) &&
                !(ea && es && !ee && ta == ew) && !(ea && es && ee && tk == ek);
        ok = 0;
        m_pa = ea; m_pe = ee; m_ps = es; m_na = en; m_nb = enb;
        if (v) begin
            case (k)
                2'd0: ok = rd_ok;
                2'd3: ok = rd_ok && m_bv;
                2'd1: begin
                    if (!ea) begin
                        ok = 1; m_pa = 1; m_pe = 0; m_ps = 0; m_pb = tb; m_pk = tk; m_pw = ta;
                    end else if (ee && es && !en && tk != ek) begin
                        ok = 1; m_na = 1; m_nb = tb;
                    end
                end
                default: begin
                    if (!ea) begin
                        ok = 1; m_pa = 1; m_pe = 1; m_ps = 0; m_pb = tb; m_pk = tk; m_pw = ta;
                    end
                end
            endcase
            if (ok && (k == 2'd0 || k == 2'd3)) begin m_bp = ta; m_bv = 1; end
        end
        xb = (m_pa && !m_ps) || m_na;
        xs = m_pa && m_ps;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (grant !== (v && ok) || reject !== (v && !ok) || busy !== xb || suspended !== xs ||
            (v && (rsp_bank !== tb || rsp_block !== tk))) begin
            fails++;
            $display("FAIL %s: g/r/busy/susp=%b%b%b%b expected %b%b%b%b bank %0d exp %0d block %0d exp %0d",
                     tag, grant, reject, busy, suspended, v && ok, v && !ok, xb, xs,
                     rsp_bank, tb, rsp_block, tk);
        end
        req_valid = 0; ctl_done = 0; ctl_suspend = 0; ctl_resume = 0;
    endtask

    task automatic idle(input string tag);
        step(0, 2'd0, '0, 0, 0, 0, tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R3: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [22:0] ra;
        logic [1:0]  rk;
        void'($urandom(32'd97531));
        m_pa = 0; m_pe = 0; m_ps = 0; m_na = 0; m_bv = 0;
        m_pb = '0; m_nb = '0; m_pk = '0; m_pw = '0; m_bp = '0;
        repeat (3) @(negedge clk);
        // R3 R10: reset state
        checks++;
        if (grant !== 0 || reject !== 0 || busy !== 0 || suspended !== 0) begin
            fails++;
            $display("FAIL R3 reset: g/r/busy/susp=%b%b%b%b expected 0000", grant, reject, busy, suspended);
        end
        rst_n = 1'b1;
        idle("R3");
        // R11: burst step with no granted read yet is rejected
        step(1, 2'd3, '0, 0, 0, 0, "R11");
        // R1 R2: decode corners
        step(1, 2'd0, 23'h000000, 0, 0, 0, "R1");
        step(1, 2'd0, 23'h7EFFFF, 0, 0, 0, "R2");
        step(1, 2'd0, 23'h7F0000, 0, 0, 0, "R2");
        step(1, 2'd0, 23'h7F4000, 0, 0, 0, "R2");
        step(1, 2'd0, 23'h7FFFFF, 0, 0, 0, "R2");
        // R11: wrap from the top, then cross a bank boundary
        step(1, 2'd3, '0, 0, 0, 0, "R11");
        step(1, 2'd0, 23'h07FFFF, 0, 0, 0, "R11");
        step(1, 2'd3, '0, 0, 0, 0, "R11");
        // R4 R5: erase in bank 2
        step(1, 2'd2, 23'h100000, 0, 0, 0, "R4");
        step(1, 2'd0, 23'h120000, 0, 0, 0, "R5");
        step(1, 2'd0, 23'h180000, 0, 0, 0, "R5");
        step(1, 2'd1, 23'h300000, 0, 0, 0, "R4");
        step(1, 2'd2, 23'h300000, 0, 0, 0, "R4");
        // R6 R7: suspend the erase
        step(0, 2'd0, '0, 0, 1, 0, "R6");
        step(1, 2'd0, 23'h120000, 0, 0, 0, "R7");
        step(1, 2'd0, 23'h100010, 0, 0, 0, "R7");
        step(1, 2'd1, 23'h100020, 0, 0, 0, "R7");
        step(1, 2'd2, 23'h400000, 0, 0, 0, "R7");
        // R9: nested program and held resume
        step(1, 2'd1, 23'h110000, 0, 0, 0, "R9");
        step(0, 2'd0, '0, 0, 0, 1, "R9");
        step(1, 2'd1, 23'h140000, 0, 0, 0, "R9");
        step(1, 2'd0, 23'h130000, 0, 0, 0, "R9");
        step(0, 2'd0, '0, 1, 0, 0, "R9");
        step(0, 2'd0, '0, 0, 0, 1, "R6");
        // R10: finish, then a completion with nothing running
        step(0, 2'd0, '0, 1, 0, 0, "R10");
        step(0, 2'd0, '0, 1, 0, 0, "R10");
        step(0, 2'd0, '0, 0, 1, 0, "R6");
        // R8 R12: program, suspend in the same cycle as a read of its word
        step(1, 2'd1, 23'h200005, 0, 0, 0, "R8");
        step(1, 2'd0, 23'h200005, 0, 1, 0, "R12");
        step(1, 2'd0, 23'h200006, 0, 0, 0, "R8");
        step(1, 2'd2, 23'h500000, 0, 0, 0, "R8");
        step(1, 2'd1, 23'h500000, 0, 0, 0, "R8");
        step(0, 2'd0, '0, 0, 0, 1, "R6");
        // R12: completion and a new program in one cycle
        step(1, 2'd1, 23'h300000, 1, 0, 0, "R12");
        step(1, 2'd2, 23'h600000, 1, 0, 0, "R12");
        // R12: erase suspended, resume collides with a nested program
        step(0, 2'd0, '0, 0, 1, 0, "R12");
        step(1, 2'd1, 23'h610000, 0, 0, 1, "R12");
        step(0, 2'd0, '0, 1, 0, 0, "R10");
        // R11: rejected burst step does not advance
        step(1, 2'd0, 23'h07FFFE, 0, 0, 0, "R11");
        step(1, 2'd2, 23'h080000, 0, 0, 0, "R11");
        step(1, 2'd3, '0, 0, 0, 0, "R11");
        step(1, 2'd3, '0, 0, 0, 0, "R11");
        step(1, 2'd3, '0, 0, 0, 0, "R11");
        step(1, 2'd3, '0, 1, 0, 0, "R11");
        // Random phase with collisions (R12 and all others)
        for (int i = 0; i < 4000; i++) begin
            case ($urandom % 4)
                0: ra = 23'($urandom);
                1: ra = m_pw ^ 23'($urandom % 4);
                2: ra = {4'hF, 19'($urandom)};
                default: ra = {m_pb, 19'($urandom)};
            endcase
            rk = 2'($urandom % 4);
            step(($urandom % 10) < 7, rk, ra, ($urandom % 10) == 0,
                 ($urandom % 10) == 0, ($urandom % 10) == 0, "R12");
        end
        finished = 1;
        summary();
        $finish;
    end
endmodule